// File: doc/BRIEF.md
# Dual-Mode Serial Bit-Rate Tick Generator

This block produces the bit-rate tick that a serial transceiver uses to pace its shifting. An 8-bit divisor X, written by software through a simple write strobe, sets the rate. A mode input chooses the prescale. Asynchronous operation divides the system clock by 64·(X+1). Synchronous operation with the internal clock source divides it by 4·(X+1). The output is a pulse one system clock wide. Consecutive pulses are exactly one full period apart.

A write to the divisor restarts the timing at once, so the new rate starts without waiting for the old count to finish. A change of the mode input or of the clock-source select also restarts the timing. When the transceiver is a synchronous slave, its clock comes from outside, so the generator holds its tick low. The divisor register is not cleared by reset and keeps its value across resets.

Top module: `bitrate_tick_gen`

## Requirements
- R1: With sync_mode = 0, consecutive tick pulses are exactly 64·(X+1) clocks apart, where X is the stored divisor (X = 25 gives 1664 clocks).
- R2: With sync_mode = 1 and int_clk_sel = 1, consecutive tick pulses are exactly 4·(X+1) clocks apart.
- R3: The divisor extremes behave the same way: X = 0 gives 64 or 4 clocks, and X = 255 gives 16384 or 1024 clocks.
- R4: A divisor write at clock edge w produces no tick on that edge. The next tick appears at edge w + P·(X_new+1), where P is 64 or 4 depending on the mode.
- R5: A change of sync_mode or int_clk_sel sampled at edge m produces no tick on that edge. The next tick appears at edge m + P·(X+1), using the new mode.
- R6: While sync_mode = 1 and int_clk_sel = 0 (synchronous slave), tick stays 0. After a return to the internal source, the first tick comes one full period after the edge where the change was sampled.
- R7: tick is high for exactly one clock per period.
- R8: Reset does not change the divisor. After reset, the period still uses the last written X.
- R9: While rst (synchronous, active high) is sampled high, tick is 0. The first tick after reset appears one full period after the last edge on which rst was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; clears the timing but not the divisor |
| div_wr | input | 1 | Divisor write strobe, one clock per write |
| div_wdata | input | 8 | Divisor value X written when div_wr is high |
| sync_mode | input | 1 | 0 = asynchronous (divide by 64·(X+1)), 1 = synchronous (divide by 4·(X+1)) |
| int_clk_sel | input | 1 | 1 = internal clock source (master); 0 in synchronous mode silences the tick |
| tick | output | 1 | One-clock bit-rate pulse |

## Verification
The bench goes after the phase of the first tick following each restart cause: a divisor write in the middle of a period, a mode switch, a return from slave to master, and reset release. A design that let the old count run out, or kept stale prescaler state, would place that first tick early or late by up to one prescale step. The divisor extremes 0 and 255 are measured in both modes, which would expose an off-by-one in the reload or a counter wrapping at the wrong width. A reset pulse without a rewrite checks that the divisor survives, and a long slave interval checks that no stray pulse escapes.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;

    typedef struct packed {
        logic sync;
        logic int_src;
    } tick_cfg_t;

    function automatic logic cfg_active(tick_cfg_t c);
        return (!c.sync) || c.int_src;
    endfunction

endpackage

// File: rtl/tick_divisor_reg.sv
module tick_divisor_reg #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] q
);
    // deliberately without reset: the value survives every reset
    always_ff @(posedge clk) begin
        if (wr) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int ASYNC_PRE = 64,
    parameter int SYNC_PRE  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sync_sel,
    output logic strobe
);
    localparam int PRE_W = (ASYNC_PRE > 2) ? $clog2(ASYNC_PRE) : 1;
    localparam logic [PRE_W-1:0] A_LIM = PRE_W'(ASYNC_PRE - 1);
    localparam logic [PRE_W-1:0] S_LIM = PRE_W'(SYNC_PRE - 1);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit  = sync_sel ? S_LIM : A_LIM;
        strobe = (cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tick_period_counter.sv
module tick_period_counter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [DIV_W-1:0] reload_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt  <= reload_val;
            tick <= 1'b0;
        end else if (step) begin
            if (cnt == '0) begin
                cnt  <= reload_val;
                tick <= 1'b1;
            end else begin
                cnt  <= cnt - 1'b1;
                tick <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/bitrate_tick_gen.sv
module bitrate_tick_gen
    import bitrate_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int ASYNC_PRE = 64,
    parameter int SYNC_PRE  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             sync_mode,
    input  logic             int_clk_sel,
    output logic             tick
);
    tick_cfg_t        cfg_now;
    tick_cfg_t        cfg_q;
    logic             restart;
    logic             pre_strobe;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] reload_val;

    always_comb begin
        cfg_now.sync    = sync_mode;
        cfg_now.int_src = int_clk_sel;
        restart    = div_wr || (cfg_now != cfg_q) || !cfg_active(cfg_now);
        reload_val = div_wr ? div_wdata : div_q;
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
    end

    tick_divisor_reg #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .wr    (div_wr),
        .wdata (div_wdata),
        .q     (div_q)
    );

    tick_prescaler #(.ASYNC_PRE(ASYNC_PRE), .SYNC_PRE(SYNC_PRE)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .clear    (restart),
        .sync_sel (sync_mode),
        .strobe   (pre_strobe)
    );

    tick_period_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .clear      (restart),
        .step       (pre_strobe),
        .reload_val (reload_val),
        .tick       (tick)
    );
endmodule

// File: rtl/bitrate_tick_gen_chk.sv
module bitrate_tick_gen_chk (
    input logic clk,
    input logic rst,
    input logic div_wr,
    input logic sync_mode,
    input logic int_clk_sel,
    input logic tick
);
    p_tick_single_r7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    p_slave_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && !int_clk_sel) |=> !tick);

    p_write_restart_r4: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> !tick);

    p_mode_restart_r5: assert property (@(posedge clk) disable iff (rst)
        ((sync_mode != $past(sync_mode)) || (int_clk_sel != $past(int_clk_sel))) |=> !tick);

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> !tick);
endmodule

bind bitrate_tick_gen bitrate_tick_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .div_wr      (div_wr),
    .sync_mode   (sync_mode),
    .int_clk_sel (int_clk_sel),
    .tick        (tick)
);

// File: tb/bitrate_tick_gen_tb_top.sv
`timescale 1ns/1ps
module bitrate_tick_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       div_wr = 1'b0;
    logic [7:0] div_wdata = 8'd0;
    logic       sync_mode = 1'b0;
    logic       int_clk_sel = 1'b0;
    logic       tick;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    r_edge = 0;
    int    m_div = 0;
    logic  m_sync = 1'b0;
    logic  m_src = 1'b0;
    logic  exp_tick = 1'b0;
    string cur_req = "R9";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    bitrate_tick_gen dut_i (
        .clk(clk), .rst(rst), .div_wr(div_wr), .div_wdata(div_wdata),
        .sync_mode(sync_mode), .int_clk_sel(int_clk_sel), .tick(tick)
    );

    // behavioural reference: tick at every full period since the last restart edge
    always @(posedge clk) begin
        int  per;
        bit  rs;
        cyc = cyc + 1;
        rs = rst || div_wr || (sync_mode != m_sync) || (int_clk_sel != m_src)
             || (sync_mode && !int_clk_sel);
        m_sync = sync_mode;
        m_src  = int_clk_sel;
        if (div_wr) m_div = div_wdata;
        per = (sync_mode ? 4 : 64) * (m_div + 1);
        if (rs) begin
            r_edge   = cyc;
            exp_tick = 1'b0;
        end else begin
            exp_tick = (((cyc - r_edge) % per) == 0);
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            total = total + 1;
            if (tick !== exp_tick) begin
                bad = bad + 1;
                $display("FAIL %s cycle %0d tick actual=%0b expected=%0b", cur_req, cyc, tick, exp_tick);
            end
        end
    end

    task automatic check_eq(string req, int act, int expv);
        total = total + 1;
        if (act != expv) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (tick !== 1'b1);
    endtask

    // measure the distance between two consecutive ticks
    task automatic gap_check(string req, int expv);
        int t0;
        wait_tick();
        t0 = cyc;
        wait_tick();
        check_eq(req, cyc - t0, expv);
    endtask

    // write a divisor and measure the delay to the first tick
    task automatic write_check(string req, int x, int expv);
        int w;
        @(negedge clk);
        div_wr = 1'b1; div_wdata = 8'(x);
        @(negedge clk);
        div_wr = 1'b0;
        w = cyc;
        wait_tick();
        check_eq(req, cyc - w, expv);
    endtask

    task automatic mode_check(string req, logic s, logic src, int expv);
        int m;
        @(negedge clk);
        sync_mode = s; int_clk_sel = src;
        @(negedge clk);
        m = cyc;
        wait_tick();
        check_eq(req, cyc - m, expv);
    endtask

    initial begin
        int l_rst;
        int ticks;
        // reset with divisor initialised to 0 for determinism (R9)
        @(negedge clk);
        div_wr = 1'b1; div_wdata = 8'd0;
        @(negedge clk);
        div_wr = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R9", int'(tick), 0);
        rst = 1'b0;
        l_rst = cyc;
        wait_tick();
        check_eq("R9", cyc - l_rst, 64);

        cur_req = "R3";
        gap_check("R3", 64);
        mode_check("R3", 1'b1, 1'b1, 4);
        gap_check("R3", 4);

        cur_req = "R1";
        mode_check("R5", 1'b0, 1'b1, 64);
        write_check("R4", 25, 1664);
        gap_check("R1", 1664);
        gap_check("R1", 1664);

        cur_req = "R5";
        mode_check("R5", 1'b1, 1'b1, 104);
        cur_req = "R2";
        gap_check("R2", 104);

        // write in the middle of a period
        cur_req = "R4";
        mode_check("R5", 1'b0, 1'b1, 1664);
        repeat (500) @(negedge clk);
        write_check("R4", 10, 704);
        gap_check("R1", 704);

        // synchronous slave: silent
        cur_req = "R6";
        @(negedge clk);
        sync_mode = 1'b1; int_clk_sel = 1'b0;
        ticks = 0;
        repeat (3000) begin
            @(negedge clk);
            if (tick === 1'b1) ticks = ticks + 1;
        end
        check_eq("R6", ticks, 0);
        mode_check("R6", 1'b1, 1'b1, 44);
        cur_req = "R2";
        gap_check("R2", 44);

        // reset keeps the divisor
        cur_req = "R8";
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R9", int'(tick), 0);
        rst = 1'b0;
        l_rst = cyc;
        wait_tick();
        check_eq("R8", cyc - l_rst, 44);
        gap_check("R8", 44);

        // divisor maximum in both modes
        cur_req = "R3";
        write_check("R3", 255, 1024);
        gap_check("R3", 1024);
        mode_check("R3", 1'b0, 1'b1, 16384);
        gap_check("R3", 16384);

        // single-cycle width
        cur_req = "R7";
        wait_tick();
        @(negedge clk);
        check_eq("R7", int'(tick), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL %s watchdog actual=running expected=finished", cur_req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule